// File: doc/BRIEF.md
# Flash Command Decoder

This block is the command front end of a byte-wide NOR flash device. It watches the processor's write cycles and uses the data byte of each write to pick what later reads return. Reads can return the memory array, two fixed identifier bytes, or a status byte.

The block also spots the two-write erase sequence, which is an erase setup byte followed by a confirm byte. It then tells a separate write engine to start, suspend or resume an erase, using one-cycle request pulses. It holds two sticky error flags that only a clear command or a power event resets.

The read mode is a state machine with four states:
- **ARRAY** (code 0)
- **IDENT** (code 1)
- **STATUS** (code 2)
- **ERSETUP** (code 3)

Transitions from ARRAY, IDENT and STATUS:
- **to_array**: byte FFh, taken only when the engine is idle.
- **to_ident**: byte 90h.
- **to_status**: byte 70h.
- **clear**: byte 50h clears the flags and keeps the state.
- **setup**: byte 20h moves to ERSETUP, taken only when the engine is idle.
- **suspend**: byte B0h, while an erase runs and is not yet suspended, moves to STATUS.
- **resume**: byte D0h, while the erase is suspended, moves to STATUS.

Transitions from ERSETUP:
- **confirm**: byte D0h starts the erase and moves to STATUS.
- **abort**: any other byte sets both error flags and moves to STATUS.

Reset and **wake** (leaving deep power-down) force ARRAY from any state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and in the cycle after `dpd_wake` is high, `rd_mode` is 0 (ARRAY) and both error flags are clear. `dpd_wake` takes priority over a write in the same cycle.
- R2: In ARRAY, `rd_data` equals `arr_rdata`. A write of FFh with `eng_busy` low selects ARRAY.
- R3: A write of 90h selects IDENT (`rd_mode` 1). In IDENT, a read at address 0 returns 89h, a read at address 1 returns A2h, and any other address returns 00h.
- R4: A write of 70h selects STATUS (`rd_mode` 2). In STATUS and ERSETUP, `rd_data` is the status byte:
  - bit 7: not `eng_busy`
  - bit 6: `eng_suspended`
  - bit 5: erase error
  - bit 4: byte-write error
  - bits 3..0: zero
- R5: The mode is sticky. Reads never change it, and a byte that is not a recognised command leaves the mode and the flags unchanged.
- R6: A write of 20h followed by a write of D0h gives one `erase_start` pulse in the cycle after the confirm. `erase_blk` is then the top `BLK_W` bits of the confirm's address, and `rd_mode` becomes 2.
- R7: A write of 20h followed by any byte other than D0h gives no `erase_start`, sets both error flags, and selects STATUS.
- R8: A write of 50h clears both error flags and leaves the mode unchanged.
- R9: While `eng_busy` is high, a write of FFh is ignored.
- R10: A write of B0h while `eng_busy` is high and `eng_suspended` is low gives one `suspend_req` pulse and selects STATUS. Otherwise B0h is ignored.
- R11: A write of D0h, outside ERSETUP, while `eng_suspended` is high gives one `resume_req` pulse and selects STATUS. Otherwise it is ignored.
- R12: While `eng_busy` is high, a write of 20h is ignored and does not enter ERSETUP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dpd_wake | input | 1 | Exit from deep power-down; forces ARRAY |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the write cycle |
| wr_data | input | 8 | Command byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data for the current mode |
| arr_rdata | input | 8 | Data from the array storage |
| eng_busy | input | 1 | Write engine is running an operation |
| eng_suspended | input | 1 | Write engine has suspended its erase |
| erase_start | output | 1 | One-cycle erase start request |
| erase_blk | output | BLK_W | Block selected by the last erase confirm |
| suspend_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |
| rd_mode | output | 2 | Current read mode code (0..3) |

## Verification
The bench builds the block with `ADDR_W` = 8 and `BLK_W` = 3. With these values the random reads hit identifier addresses 0 and 1 often, and every one of the eight erase blocks can be selected by a confirm write.

Random command bytes are drawn mostly from the recognised set, with a share of stray bytes. Random toggling of `eng_busy` and `eng_suspended` makes the busy-gated, suspend and resume branches occur in many orders. Directed steps cover the abort path, clearing the flags, and the wake event.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY   = 2'd0,
        MODE_IDENT   = 2'd1,
        MODE_STATUS  = 2'd2,
        MODE_ERSETUP = 2'd3
    } rd_mode_e;

    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_SETUP   = 8'h20;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;

    typedef struct packed {
        logic ready;
        logic suspended;
        logic erase_err;
        logic write_err;
        logic [3:0] zero;
    } status_t;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dpd_wake,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              eng_busy,
    input  logic              eng_suspended,
    output rd_mode_e          mode,
    output logic              set_errs,
    output logic              clr_errs,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              suspend_req,
    output logic              resume_req
);

    rd_mode_e state, nxt;
    logic     hit_erase, hit_susp, hit_res;

    always_comb begin
        nxt       = state;
        hit_erase = 1'b0;
        hit_susp  = 1'b0;
        hit_res   = 1'b0;
        set_errs  = 1'b0;
        clr_errs  = 1'b0;
        if (wr_en) begin
            unique case (state)
                MODE_ERSETUP: begin
                    nxt = MODE_STATUS;
                    if (wr_data == OP_CONFIRM) hit_erase = 1'b1;
                    else                       set_errs  = 1'b1;
                end
                MODE_ARRAY, MODE_IDENT, MODE_STATUS: begin
                    case (wr_data)
                        OP_ARRAY:  if (!eng_busy) nxt = MODE_ARRAY;
                        OP_IDENT:  nxt = MODE_IDENT;
                        OP_STATUS: nxt = MODE_STATUS;
                        OP_CLEAR:  clr_errs = 1'b1;
                        OP_SETUP:  if (!eng_busy) nxt = MODE_ERSETUP;
                        OP_SUSPEND: if (eng_busy && !eng_suspended) begin
                            hit_susp = 1'b1;
                            nxt      = MODE_STATUS;
                        end
                        OP_CONFIRM: if (eng_suspended) begin
                            hit_res = 1'b1;
                            nxt     = MODE_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= MODE_ARRAY;
        else if (dpd_wake) state <= MODE_ARRAY;
        else               state <= nxt;
    end

    // registered request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_start <= 1'b0;
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
            erase_blk   <= '0;
        end else begin
            erase_start <= hit_erase && !dpd_wake;
            suspend_req <= hit_susp  && !dpd_wake;
            resume_req  <= hit_res   && !dpd_wake;
            if (hit_erase && !dpd_wake) erase_blk <= wr_addr[ADDR_W-1 -: BLK_W];
        end
    end

    assign mode = state;

endmodule

// File: rtl/flash_err_flags.sv
module flash_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic dpd_wake,
    input  logic set_errs,
    input  logic clr_errs,
    output logic erase_err,
    output logic write_err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_err <= 1'b0;
            write_err <= 1'b0;
        end else if (dpd_wake || clr_errs) begin
            erase_err <= 1'b0;
            write_err <= 1'b0;
        end else if (set_errs) begin
            erase_err <= 1'b1;
            write_err <= 1'b1;
        end
    end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter logic [7:0]  MFR_CODE = 8'h89,
    parameter logic [7:0]  DEV_CODE = 8'hA2
) (
    input  rd_mode_e          mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    input  status_t           status,
    output logic [7:0]        rd_data
);

    logic [7:0] ident_byte;

    always_comb begin
        if (rd_addr == ADDR_W'(0))      ident_byte = MFR_CODE;
        else if (rd_addr == ADDR_W'(1)) ident_byte = DEV_CODE;
        else                            ident_byte = 8'h00;
    end

    always_comb begin
        unique case (mode)
            MODE_ARRAY:                rd_data = arr_rdata;
            MODE_IDENT:                rd_data = ident_byte;
            MODE_STATUS, MODE_ERSETUP: rd_data = status;
        endcase
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dpd_wake,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [7:0]        arr_rdata,
    input  logic              eng_busy,
    input  logic              eng_suspended,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [1:0]        rd_mode
);

    rd_mode_e mode;
    logic     set_errs, clr_errs, erase_err, write_err;
    status_t  status;

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .dpd_wake(dpd_wake),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_suspended(eng_suspended),
        .mode(mode), .set_errs(set_errs), .clr_errs(clr_errs),
        .erase_start(erase_start), .erase_blk(erase_blk),
        .suspend_req(suspend_req), .resume_req(resume_req)
    );

    flash_err_flags u_flags (
        .clk(clk), .rst_n(rst_n), .dpd_wake(dpd_wake),
        .set_errs(set_errs), .clr_errs(clr_errs),
        .erase_err(erase_err), .write_err(write_err)
    );

    assign status = '{ready: ~eng_busy, suspended: eng_suspended,
                      erase_err: erase_err, write_err: write_err, zero: 4'h0};

    flash_read_mux #(.ADDR_W(ADDR_W)) u_mux (
        .mode(mode), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .status(status), .rd_data(rd_data)
    );

    assign rd_mode = mode;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dpd_wake,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              eng_busy,
    input logic              erase_start,
    input logic              suspend_req,
    input logic              resume_req,
    input logic [1:0]        rd_mode,
    input logic              erase_err,
    input logic              write_err
);

    // R1
    wake_to_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_wake |=> (rd_mode == 2'd0 && !erase_err && !write_err));

    // R9
    busy_array_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dpd_wake && eng_busy && wr_data == 8'hFF && rd_mode != 2'd3)
        |=> $stable(rd_mode));

    // R6
    start_in_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> rd_mode == 2'd2);

    // R7
    abort_sets_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dpd_wake && rd_mode == 2'd3 && wr_data != 8'hD0)
        |=> (erase_err && write_err && rd_mode == 2'd2 && !erase_start));

    // R8
    clear_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_mode != 2'd3 && wr_data == 8'h50) |=> (!erase_err && !write_err));

    // R10
    suspend_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend_req) |-> $past(eng_busy));

    // R6
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_start, suspend_req, resume_req}));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dpd_wake(dpd_wake), .wr_en(wr_en),
    .wr_data(wr_data), .eng_busy(eng_busy), .erase_start(erase_start),
    .suspend_req(suspend_req), .resume_req(resume_req), .rd_mode(rd_mode),
    .erase_err(erase_err), .write_err(write_err)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int BLK_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dpd_wake = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data, arr_rdata;
    logic eng_busy = 1'b0, eng_suspended = 1'b0;
    logic erase_start, suspend_req, resume_req;
    logic [BLK_W-1:0] erase_blk;
    logic [1:0] rd_mode;

    int total = 0, bad = 0;
    int m_mode = 0;
    bit m_ee = 0, m_we = 0;
    bit e_start, e_susp, e_res;
    logic [BLK_W-1:0] m_blk = '0;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dpd_wake(dpd_wake), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .arr_rdata(arr_rdata), .eng_busy(eng_busy),
        .eng_suspended(eng_suspended), .erase_start(erase_start),
        .erase_blk(erase_blk), .suspend_req(suspend_req),
        .resume_req(resume_req), .rd_mode(rd_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_val(logic [ADDR_W-1:0] a);
        return 8'(a * 37 + 5);
    endfunction

    assign arr_rdata = mem_val(rd_addr);

    function automatic logic [7:0] exp_read(logic [ADDR_W-1:0] a);
        case (m_mode)
            0: return mem_val(a);
            1: return (a == 0) ? 8'h89 : (a == 1) ? 8'hA2 : 8'h00;
            default: return {~eng_busy, eng_suspended, m_ee, m_we, 4'h0};
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [7:0] d, logic [ADDR_W-1:0] a);
        e_start = 0; e_susp = 0; e_res = 0;
        if (m_mode == 3) begin
            if (d == 8'hD0) begin e_start = 1; m_blk = a[ADDR_W-1 -: BLK_W]; end
            else begin m_ee = 1; m_we = 1; end
            m_mode = 2;
        end else begin
            case (d)
                8'hFF: if (!eng_busy) m_mode = 0;
                8'h90: m_mode = 1;
                8'h70: m_mode = 2;
                8'h50: begin m_ee = 0; m_we = 0; end
                8'h20: if (!eng_busy) m_mode = 3;
                8'hB0: if (eng_busy && !eng_suspended) begin e_susp = 1; m_mode = 2; end
                8'hD0: if (eng_suspended) begin e_res = 1; m_mode = 2; end
                default: ;
            endcase
        end
    endtask

    task automatic do_write(logic [7:0] d, logic [ADDR_W-1:0] a, string req);
        @(negedge clk);
        model_write(d, a);
        wr_en = 1'b1; wr_data = d; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
        check(int'(rd_mode) == m_mode, {req, " mode"}, int'(rd_mode), m_mode);
        check(erase_start == e_start, {req, " erase_start"}, int'(erase_start), int'(e_start));
        check(suspend_req == e_susp, {req, " suspend_req"}, int'(suspend_req), int'(e_susp));
        check(resume_req == e_res, {req, " resume_req"}, int'(resume_req), int'(e_res));
        if (e_start)
            check(erase_blk == m_blk, {req, " erase_blk"}, int'(erase_blk), int'(m_blk));
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, string req);
        rd_addr = a;
        #1;
        check(rd_data == exp_read(a), {req, " rd_data"}, int'(rd_data), int'(exp_read(a)));
    endtask

    task automatic set_engine(bit b, bit s);
        @(negedge clk);
        eng_busy = b; eng_suspended = s;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R2 array read
        check(rd_mode == 2'd0, "R1 reset mode", int'(rd_mode), 0);
        do_read(8'h3C, "R2");
        do_write(8'hFF, 8'h00, "R2");
        do_read(8'h81, "R2");
        // R3 identifier
        do_write(8'h90, 8'h00, "R3");
        do_read(8'h00, "R3"); do_read(8'h01, "R3"); do_read(8'h07, "R3");
        // R5 stray byte keeps mode, reads keep mode
        do_write(8'h33, 8'h10, "R5");
        do_read(8'h01, "R5");
        // R4 status
        do_write(8'h70, 8'h00, "R4");
        do_read(8'h00, "R4");
        // R6 erase sequence, top block
        do_write(8'h20, 8'hE0, "R6");
        do_write(8'hD0, 8'hE5, "R6");
        do_read(8'h00, "R6");
        // R7 bad confirm
        do_write(8'h20, 8'h00, "R7");
        do_write(8'h44, 8'h00, "R7");
        do_read(8'h00, "R7");
        // R8 clear keeps mode
        do_write(8'h90, 8'h00, "R8");
        do_write(8'h50, 8'h00, "R8");
        do_write(8'h70, 8'h00, "R8");
        do_read(8'h00, "R8");
        // R9 busy ignores array read, R12 busy ignores setup
        set_engine(1, 0);
        do_write(8'hFF, 8'h00, "R9");
        do_read(8'h02, "R9");
        do_write(8'h20, 8'h00, "R12");
        do_read(8'h02, "R12");
        // R10 suspend
        do_write(8'h90, 8'h00, "R10");
        do_write(8'hB0, 8'h00, "R10");
        do_read(8'h00, "R10");
        // R11 resume
        set_engine(1, 1);
        do_write(8'hB0, 8'h00, "R10");
        do_write(8'hD0, 8'h00, "R11");
        do_read(8'h00, "R11");
        set_engine(0, 0);
        // R1 wake from power-down with errors pending
        do_write(8'h20, 8'h00, "R7");
        do_write(8'h11, 8'h00, "R7");
        @(negedge clk); dpd_wake = 1'b1; wr_en = 1'b1; wr_data = 8'h70;
        @(negedge clk); dpd_wake = 1'b0; wr_en = 1'b0;
        m_mode = 0; m_ee = 0; m_we = 0;
        check(rd_mode == 2'd0, "R1 wake mode", int'(rd_mode), 0);
        do_write(8'h70, 8'h00, "R1");
        do_read(8'h00, "R1");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ops [8] = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'hD0, 8'hB0, 8'h00};
            logic [7:0] d;
            int k = int'($urandom_range(0, 7));
            d = (k == 7) ? 8'($urandom) : ops[k];
            if ($urandom_range(0, 3) == 0)
                set_engine(1'($urandom), 1'($urandom));
            do_write(d, ADDR_W'($urandom), "R5 random");
            do_read(ADDR_W'($urandom_range(0, 3)), "R3 random");
            do_read(ADDR_W'($urandom), "R4 random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule